// File: doc/BRIEF.md
# I2C Register Target with Transaction Watchdog

This block is an I2C target that exposes a byte-wide register space through 16-bit register addresses. SCL and SDA are resynchronised into a free-running master clock. The block pulls SDA low through an open-drain enable, and it reaches the register storage through a simple synchronous port. That port carries an address, write data, a one-cycle write strobe, a one-cycle read strobe, and read data that comes back one cycle after the read strobe.

Every transaction that opens with a START on an idle bus arms a watchdog counted in master-clock cycles. Repeated STARTs inside the transaction leave the count running. When the limit is reached, the target lets go of SDA at once, whatever bit it is in. From then on the master reads all-ones data, gets no acknowledge on written bytes, and may see a false STOP if SDA was being held low while SCL was high. The target stays deaf until a real STOP, which clears and re-arms the watchdog.

The register address is sent high byte first. Multi-byte writes and reads step the address by one after every data byte.

Top module: `i2c_regtarget_wdog`

## Requirements
- R1: The target acknowledges only the address byte whose upper seven bits equal the 7-bit device address (default 0x1A, so 0x34 to write and 0x35 to read; bit 0 is 1 for read). A byte with any other address gets no acknowledge and causes no register strobe.
- R2: In a write, the bytes after the address byte are register address high, register address low, then data. Every byte is acknowledged, and each data byte raises `reg_we` for exactly one cycle with the 16-bit address and the data on the port.
- R3: Further data bytes in the same write go to the register address plus one, plus two, and so on, wrapping at 16 bits.
- R4: A read uses the same two-byte address, then a repeated START, then 0x35. The target pulses `reg_re` with that address and shifts the returned byte onto SDA MSB first. `reg_we` and `reg_re` are never high together.
- R5: While the master acknowledges a read byte, the target fetches and sends the next address. A master NACK ends the read with no further `reg_re`.
- R6: The watchdog starts at a START seen on an idle bus and expires WDOG_LIMIT master-clock cycles later (default 2^18+8). It counts up by one per cycle, and repeated STARTs do not clear or restart it.
- R7: On expiry, SDA is released within one master-clock cycle in any bit phase, including while SCL is high, where the rising SDA looks like a STOP. Later read bits are 1 (byte 0xFF), later written bytes get a NACK, and no register strobe is raised.
- R8: After expiry, STARTs and address bytes are ignored (no acknowledge) until a real STOP.
- R9: A STOP clears the watchdog and re-arms it, so the next transaction behaves normally.
- R10: During and after reset, `sda_oe`, `reg_we` and `reg_re` are low.
- R11: START and STOP are SDA falling and rising edges while the synchronised SCL is high. SDA changes while SCL is low are data and do not disturb a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL as seen on the bus |
| sda_i | input | 1 | SDA as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when high |
| reg_addr | output | 16 | Register address for the current strobe |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_re | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 8 | Register read data, valid one cycle after `reg_re` |

## Verification
The properties assume that the SCL half period is many master-clock cycles long. With that spacing, byte boundaries never coincide, so a write strobe is always followed by an idle cycle, and reads and writes cannot overlap. They also assume that SDA moves only while SCL is low, except for a deliberate START or STOP, so that the edge detector never sees a spurious condition. The bench keeps to this by holding each SCL phase for 25 cycles and by changing SDA only after SCL has been low for several cycles. The one deliberate exception is the test that stalls with SCL high, where the target's own release of SDA forms the false STOP.

// File: rtl/i2c_rt_pkg.sv
package i2c_rt_pkg;
    localparam int REG_AW = 16;
    localparam int REG_DW = 8;
    localparam int BIT_CW = $clog2(REG_DW);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK
    } link_st_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_DATA
    } byte_ph_e;

    typedef struct packed {
        link_st_e              st;
        byte_ph_e              ph;
        logic [BIT_CW-1:0]     bcnt;
        logic                  full;
        logic                  rd;
        logic                  more;
        logic [REG_DW-1:0]     sh;
        logic [REG_AW-1:0]     addr;
        logic                  drive;
        logic                  we;
        logic                  re;
        logic                  ld;
    } link_s;

    typedef struct packed {
        logic scl_p;
        logic sda_p;
    } cond_s;
endpackage

// File: rtl/i2c_rt_sync.sv
module i2c_rt_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    assign chain_d[0] = din;
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        assign chain_d[g] = chain_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_rt_cond.sv
module i2c_rt_cond
    import i2c_rt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    cond_s d, q;

    always_comb begin
        d       = q;
        d.scl_p = scl_s;
        d.sda_p = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_rise  = ~q.scl_p & scl_s;
    assign scl_fall  = q.scl_p & ~scl_s;
    assign start_evt = q.scl_p & scl_s & q.sda_p & ~sda_s;
    assign stop_evt  = q.scl_p & scl_s & ~q.sda_p & sda_s;
endmodule

// File: rtl/i2c_rt_wdog.sv
module i2c_rt_wdog #(
    parameter int LIMIT = (1 << 18) + 8,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_evt,
    input  logic          stop_evt,
    output logic          running,
    output logic          expired,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    typedef struct packed {
        logic          run;
        logic          exp;
        logic [CW-1:0] cnt;
    } wd_s;

    wd_s d, q;

    always_comb begin
        d = q;
        if (stop_evt) begin
            d = '0;
        end else if (start_evt && !q.run && !q.exp) begin
            d.run = 1'b1;
            d.cnt = '0;
        end else if (q.run) begin
            if (q.cnt == LAST) begin
                d.run = 1'b0;
                d.exp = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign running = q.run;
    assign expired = q.exp;
    assign count   = q.cnt;
endmodule

// File: rtl/i2c_rt_link.sv
module i2c_rt_link
    import i2c_rt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h1A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              sda_s,
    input  logic              expired,
    input  logic [REG_DW-1:0] rdata,
    output logic              sda_drive,
    output logic              we,
    output logic              re,
    output logic [REG_AW-1:0] addr,
    output logic [REG_DW-1:0] wdata
);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(REG_DW - 1);

    link_s d, q;

    always_comb begin
        d    = q;
        d.we = 1'b0;
        d.re = 1'b0;
        d.ld = q.re;
        // fetched byte lands one cycle after the strobe; address steps after use
        if (q.ld) begin
            d.sh   = rdata;
            d.addr = q.addr + 1'b1;
        end
        if (q.we) d.addr = q.addr + 1'b1;

        if (expired) begin
            d.st    = ST_IDLE;
            d.drive = 1'b0;
            d.ld    = 1'b0;
        end else if (stop_evt) begin
            d.st    = ST_IDLE;
            d.drive = 1'b0;
        end else if (start_evt) begin
            d.st    = ST_RX;
            d.ph    = PH_DEV;
            d.bcnt  = '0;
            d.full  = 1'b0;
            d.drive = 1'b0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        d.sh   = {q.sh[REG_DW-2:0], sda_s};
                        d.bcnt = q.bcnt + 1'b1;
                        d.full = (q.bcnt == LAST_BIT);
                    end
                    if (scl_fall && q.full) begin
                        d.full  = 1'b0;
                        d.bcnt  = '0;
                        d.drive = 1'b1;
                        d.st    = ST_ACK;
                        unique case (q.ph)
                            PH_DEV: begin
                                if (q.sh[REG_DW-1:1] == DEV_ADDR) begin
                                    d.rd = q.sh[0];
                                    d.re = q.sh[0];
                                    if (!q.sh[0]) d.ph = PH_AHI;
                                end else begin
                                    d.drive = 1'b0;
                                    d.st    = ST_IDLE;
                                end
                            end
                            PH_AHI: begin
                                d.addr[REG_AW-1:REG_DW] = q.sh;
                                d.ph = PH_ALO;
                            end
                            PH_ALO: begin
                                d.addr[REG_DW-1:0] = q.sh;
                                d.ph = PH_DATA;
                            end
                            default: d.we = 1'b1;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.bcnt = '0;
                        if (q.rd) begin
                            d.st    = ST_TX;
                            d.drive = ~q.sh[REG_DW-1];
                        end else begin
                            d.st    = ST_RX;
                            d.drive = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.bcnt == LAST_BIT) begin
                            d.st    = ST_TXACK;
                            d.drive = 1'b0;
                        end else begin
                            d.bcnt  = q.bcnt + 1'b1;
                            d.sh    = {q.sh[REG_DW-2:0], 1'b1};
                            d.drive = ~q.sh[REG_DW-2];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        d.more = ~sda_s;
                        d.re   = ~sda_s;
                    end
                    if (scl_fall) begin
                        if (q.more) begin
                            d.st    = ST_TX;
                            d.bcnt  = '0;
                            d.drive = ~q.sh[REG_DW-1];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_drive = q.drive;
    assign we        = q.we;
    assign re        = q.re;
    assign addr      = q.addr;
    assign wdata     = q.sh;
endmodule

// File: rtl/i2c_regtarget_wdog.sv
module i2c_regtarget_wdog
    import i2c_rt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h1A,
    parameter int         WDOG_LIMIT  = (1 << 18) + 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [REG_AW-1:0] reg_addr,
    output logic [REG_DW-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [REG_DW-1:0] reg_rdata
);
    localparam int WD_CW = $clog2(WDOG_LIMIT + 1);

    logic [1:0]       pins_s;
    logic             scl_rise, scl_fall, start_evt, stop_evt;
    logic             wd_run, wd_exp;
    logic [WD_CW-1:0] wd_cnt;

    i2c_rt_sync #(.STAGES(SYNC_STAGES), .W(2)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (pins_s)
    );

    i2c_rt_cond cond_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (pins_s[1]),
        .sda_s    (pins_s[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    i2c_rt_wdog #(.LIMIT(WDOG_LIMIT), .CW(WD_CW)) wdog_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_evt(start_evt),
        .stop_evt (stop_evt),
        .running  (wd_run),
        .expired  (wd_exp),
        .count    (wd_cnt)
    );

    i2c_rt_link #(.DEV_ADDR(DEV_ADDR)) link_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt),
        .sda_s    (pins_s[0]),
        .expired  (wd_exp),
        .rdata    (reg_rdata),
        .sda_drive(sda_oe),
        .we       (reg_we),
        .re       (reg_re),
        .addr     (reg_addr),
        .wdata    (reg_wdata)
    );
endmodule

// File: rtl/i2c_regtarget_wdog_chk.sv
module i2c_regtarget_wdog_chk #(
    parameter int LIMIT = (1 << 18) + 8,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sda_oe,
    input logic          reg_we,
    input logic          reg_re,
    input logic          wd_run,
    input logic          wd_exp,
    input logic [CW-1:0] wd_cnt,
    input logic          stop_evt
);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R2

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re)); // R4

    AST_WDOG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_run && !stop_evt && (wd_cnt != LAST)) |=> (wd_run && (wd_cnt == $past(wd_cnt) + 1'b1))); // R6

    AST_EXPIRY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_exp && $past(wd_exp)) |-> !sda_oe); // R7

    AST_EXPIRY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        wd_exp |=> (!reg_we && !reg_re)); // R8

    AST_STOP_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!wd_exp && !wd_run)); // R9
endmodule

bind i2c_regtarget_wdog i2c_regtarget_wdog_chk #(.LIMIT(WDOG_LIMIT), .CW(WD_CW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sda_oe  (sda_oe),
    .reg_we  (reg_we),
    .reg_re  (reg_re),
    .wd_run  (wd_run),
    .wd_exp  (wd_exp),
    .wd_cnt  (wd_cnt),
    .stop_evt(stop_evt)
);

// File: tb/i2c_regtarget_wdog_tb_top.sv
`timescale 1ns/1ps
module i2c_regtarget_wdog_tb_top;
    localparam int H     = 25;
    localparam int LIMIT = 4000;
    localparam logic [23:0] VEC [0:5] = '{
        24'h00005A, 24'h00FF01, 24'h1234C3,
        24'hABCD00, 24'hFFFFFF, 24'h80017E
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe, reg_we, reg_re;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    wire sda_bus = m_sda & ~sda_oe;

    logic [7:0]  mem [0:255];
    logic [15:0] wlog_a [0:63];
    logic [7:0]  wlog_d [0:63];
    int we_n = 0;
    int re_n = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_regtarget_wdog #(.WDOG_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    // register storage model with one-cycle read latency
    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr[7:0]] <= reg_wdata;
            if (we_n < 64) begin
                wlog_a[we_n] <= reg_addr;
                wlog_d[we_n] <= reg_wdata;
            end
            we_n <= we_n + 1;
        end
        if (reg_re) begin
            reg_rdata <= mem[reg_addr[7:0]];
            re_n <= re_n + 1;
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bstart();
        m_sda = 1'b1; m_scl = 1'b1; wt(H);
        m_sda = 1'b0; wt(H);
        m_scl = 1'b0; wt(H);
    endtask

    task automatic brstart();
        m_sda = 1'b1; wt(H);
        m_scl = 1'b1; wt(H);
        m_sda = 1'b0; wt(H);
        m_scl = 1'b0; wt(H);
    endtask

    task automatic bstop();
        m_sda = 1'b0; wt(H);
        m_scl = 1'b1; wt(H);
        m_sda = 1'b1; wt(H);
    endtask

    task automatic send_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wt(H);
            m_scl = 1'b1; wt(H);
            m_scl = 1'b0; wt(4);
        end
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack);
        send_bits(b);
        m_sda = 1'b1; wt(H);
        m_scl = 1'b1; wt(H / 2);
        ack = ~sda_bus;
        wt(H - H / 2);
        m_scl = 1'b0; wt(4);
    endtask

    task automatic rbyte(output logic [7:0] b, input bit ack);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(H);
            m_scl = 1'b1; wt(H / 2);
            b[i] = sda_bus;
            wt(H - H / 2);
            m_scl = 1'b0; wt(4);
        end
        m_sda = ack ? 1'b0 : 1'b1; wt(H);
        m_scl = 1'b1; wt(H);
        m_scl = 1'b0; wt(4);
        m_sda = 1'b1;
    endtask

    task automatic wr_reg(input logic [15:0] a, input logic [7:0] v, output bit ok);
        bit k0, k1, k2, k3;
        bstart();
        wbyte(8'h34, k0); wbyte(a[15:8], k1); wbyte(a[7:0], k2); wbyte(v, k3);
        bstop();
        ok = k0 & k1 & k2 & k3;
    endtask

    task automatic rd_reg(input logic [15:0] a, output logic [7:0] v, output bit ok);
        bit k0, k1, k2, k3;
        bstart();
        wbyte(8'h34, k0); wbyte(a[15:8], k1); wbyte(a[7:0], k2);
        brstart();
        wbyte(8'h35, k3);
        rbyte(v, 1'b0);
        bstop();
        ok = k0 & k1 & k2 & k3;
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ok, a0, a1, a2;
        logic [7:0] v;
        logic [7:0] rb [0:5];
        int n0, r0;

        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
        wt(6);
        chk(!sda_oe && !reg_we && !reg_re, "R10 reset quiet", {sda_oe, reg_we, reg_re}, 0);
        rst_n = 1'b1;
        wt(10);
        chk(!sda_oe && !reg_we && !reg_re, "R10 after reset", {sda_oe, reg_we, reg_re}, 0);

        // table walk: single write then single read-back
        for (int i = 0; i < 6; i++) begin
            n0 = we_n;
            wr_reg(VEC[i][23:8], VEC[i][7:0], ok);
            chk(ok, "R2 write acked", 32'(ok), 1);
            chk(we_n == n0 + 1, "R2 one write strobe", we_n - n0, 1);
            chk(wlog_a[n0] == VEC[i][23:8] && wlog_d[n0] == VEC[i][7:0], "R2 strobe addr/data",
                {wlog_a[n0], wlog_d[n0]}, VEC[i]);
            rd_reg(VEC[i][23:8], v, ok);
            chk(ok && v == VEC[i][7:0], "R4 read back", 32'(v), 32'(VEC[i][7:0]));
        end

        // R1: another address is not acknowledged
        n0 = we_n; r0 = re_n;
        bstart(); wbyte(8'h50, a0); wbyte(8'h00, a1); bstop();
        chk(!a0 && !a1, "R1 foreign address NACK", {a0, a1}, 0);
        chk(we_n == n0 && re_n == r0, "R1 no strobes", we_n - n0 + re_n - r0, 0);

        // R3: burst write with address wrap into next page
        n0 = we_n;
        bstart(); wbyte(8'h34, a0); wbyte(8'h12, a0); wbyte(8'hFE, a0);
        wbyte(8'h11, a0); wbyte(8'h22, a1); wbyte(8'h33, a2); bstop();
        chk(a0 && a1 && a2, "R3 burst acked", {a0, a1, a2}, 7);
        chk(wlog_a[n0] == 16'h12FE && wlog_a[n0+1] == 16'h12FF && wlog_a[n0+2] == 16'h1300,
            "R3 address steps", wlog_a[n0+2], 16'h1300);
        chk(wlog_d[n0+2] == 8'h33, "R3 burst data", wlog_d[n0+2], 8'h33);

        // R5: three-byte read, last NACKed, no extra fetch
        r0 = re_n;
        bstart(); wbyte(8'h34, a0); wbyte(8'h00, a0); wbyte(8'h80, a0);
        brstart(); wbyte(8'h35, a0);
        rbyte(rb[0], 1'b1); rbyte(rb[1], 1'b1); rbyte(rb[2], 1'b0); bstop();
        chk(rb[0] == (8'h80 ^ 8'hA5) && rb[1] == (8'h81 ^ 8'hA5) && rb[2] == (8'h82 ^ 8'hA5),
            "R5 sequential data", rb[2], 8'h82 ^ 8'hA5);
        chk(re_n - r0 == 3, "R5 fetch count", re_n - r0, 3);

        // R6/R7: long read through a repeated START runs into expiry
        bstart(); wbyte(8'h34, a0); wbyte(8'h00, a0); wbyte(8'h10, a0);
        brstart(); wbyte(8'h35, a0);
        for (int k = 0; k < 6; k++) rbyte(rb[k], k != 5);
        bstop();
        chk(rb[0] == (8'h10 ^ 8'hA5) && rb[1] == (8'h11 ^ 8'hA5), "R6 early bytes intact",
            rb[1], 8'h11 ^ 8'hA5);
        chk(rb[5] == 8'hFF, "R6 repeated START keeps count, late byte all ones", rb[5], 8'hFF);

        // R7/R8: stalled write gets NACK, START is ignored until STOP
        n0 = we_n;
        bstart(); wbyte(8'h34, a0); wbyte(8'h00, a0); wbyte(8'h40, a0);
        wt(3000);
        wbyte(8'h77, a1);
        chk(!a1, "R7 write after expiry NACK", 32'(a1), 0);
        brstart(); wbyte(8'h34, a2);
        chk(!a2, "R8 START ignored after expiry", 32'(a2), 0);
        bstop();
        chk(we_n == n0, "R7 no strobe after expiry", we_n - n0, 0);

        // R9: next transaction after STOP works, stalled write had no effect
        wr_reg(16'h0042, 8'h3C, ok);
        chk(ok, "R9 re-armed write acked", 32'(ok), 1);
        rd_reg(16'h0040, v, ok);
        chk(ok && v == (8'h40 ^ 8'hA5), "R9 dropped write left value", v, 8'h40 ^ 8'hA5);

        // R7/R11: expiry while holding ACK low with SCL high gives a false STOP
        bstart(); wbyte(8'h34, a0); wbyte(8'h00, a0);
        send_bits(8'h41);
        m_sda = 1'b1; wt(H);
        m_scl = 1'b1; wt(H / 2);
        chk(sda_bus == 1'b0, "R11 ACK held low with SCL high", 32'(sda_bus), 0);
        wt(3000);
        chk(sda_bus == 1'b1, "R7 released with SCL high", 32'(sda_bus), 1);
        m_scl = 1'b0; wt(H);
        bstop();
        rd_reg(16'h0042, v, ok);
        chk(ok && v == 8'h3C, "R9 normal after false STOP", v, 8'h3C);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule